// File: doc/BRIEF.md
# Load Multiple and Load String Sequencer

This block carries out the multi-register load instructions of a 32-bit integer core. One start strobe hands it the instruction kind, the destination register number RT, the base register number RA, the index register number RB, the current values of RA and RB, a 16-bit displacement, a 5-bit immediate byte count and the transfer byte count held in the fixed-point exception register. The sequencer then walks memory one byte per accepted request. It gathers the returned bytes into 32-bit words and writes each word into the register file through a single write port.

Three kinds are accepted on `kind_i`. Code 0 is load-multiple-word: the address is (RA|0) plus the sign-extended displacement, and words fill RT up to register 31. Code 1 is load-string with an immediate count, starting at (RA|0). Code 2 is load-string indexed, starting at (RA|0)+(RB). Code 3 is treated as a zero-length transfer. Here (RA|0) means the value zero when RA names register 0, and the value of RA otherwise. Destination register numbers wrap from 31 to 0. The base register, and for the indexed form the index register, is shielded from being overwritten unless it is the final register of the transfer.

Top module: `load_burst_seq`

## Requirements
- R1: For kind 0 the first byte address is (RA|0) + sign-extended displacement, the byte count is 4*(32-RT), and words are written to RT, RT+1, ... 31.
- R2: For kind 1 the first byte address is (RA|0). The byte count is the 5-bit immediate, except that an immediate of zero means 32 bytes.
- R3: For kind 2 the first byte address is (RA|0) + RB value, and the byte count is the 7-bit transfer count input.
- R4: When RA is register 0, the base used for the address is zero, whatever `ra_val_i` holds.
- R5: Bytes fill a word from bits 31:24 down to bits 7:0 in address order. The low bytes of a last word that is only partly filled are written as zero.
- R6: The destination register number increments once per word and wraps from 31 to 0. There are ceil(n/4) words, and the last register is (RT + ceil(n/4) - 1) mod 32.
- R7: No write is issued to the RA register, or to the RB register for kind 2, unless that register is the last register. This holds for register 0 as well.
- R8: With a byte count of zero there are no memory requests and no register writes, and `done_o` pulses in the cycle after the start.
- R9: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_rdy_i`. Each accepted byte advances the address by one.
- R10: `done_o` is high for exactly one cycle, in the cycle that follows the last register write.
- R11: A start strobe while a transfer is in progress is ignored and does not change the running transfer.
- R12: After reset there is no memory request, no register write and no done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| kind_i | input | 2 | 0 multiple-word, 1 string immediate, 2 string indexed |
| rt_i | input | 5 | First destination register |
| ra_i | input | 5 | Base register number |
| rb_i | input | 5 | Index register number |
| ra_val_i | input | 32 | Value of the base register |
| rb_val_i | input | 32 | Value of the index register |
| disp_i | input | 16 | Signed displacement |
| nb_i | input | 5 | Immediate byte count |
| tbc_i | input | 7 | Transfer byte count |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | 32 | Byte address |
| mem_rdy_i | input | 1 | Request accepted, byte valid this cycle |
| mem_byte_i | input | 8 | Returned byte |
| wr_en_o | output | 1 | Register write strobe |
| wr_idx_o | output | 5 | Register written |
| wr_data_o | output | 32 | Word written |
| done_o | output | 1 | Transfer complete pulse |

## Verification
The bench uses the default parameters: 32-bit words and addresses, a 16-bit displacement, a 5-bit immediate count and a 7-bit transfer count. The 7-bit count allows a 127-byte indexed transfer from RT=0. That transfer touches all 32 registers, ends on a partial word, and shields register 0 as the index register while RA is written as the final register. The 5-bit immediate allows the zero-means-32 case, whose eight words wrap past register 31. The table runs with the memory ready every cycle and with a periodic stall, so both handshake paths are covered.

// File: rtl/lms_pkg.sv
package lms_pkg;
  localparam int REG_AW = 5;
  localparam int NREGS  = 1 << REG_AW;

  typedef enum logic [1:0] {
    K_MULTI   = 2'd0,
    K_STR_IMM = 2'd1,
    K_STR_IDX = 2'd2
  } ld_kind_e;

  typedef enum logic [1:0] {
    S_IDLE, S_RUN, S_LAST, S_DONE
  } seq_state_e;

  // Number of registers covered by nbytes when each holds bpr bytes.
  function automatic int unsigned regs_for(input int unsigned nbytes, input int unsigned bpr);
    return (nbytes + bpr - 1) / bpr;
  endfunction

  // Register number step positions after r, wrapping modulo NREGS.
  function automatic logic [REG_AW-1:0] wrap_reg(input logic [REG_AW-1:0] r, input int unsigned step);
    int unsigned s;
    s = int'(r) + step;
    return s[REG_AW-1:0];
  endfunction
endpackage

// File: rtl/lms_setup.sv
module lms_setup import lms_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int NB_W   = 5,
  parameter int TBC_W  = 7,
  parameter int CNT_W  = 8
) (
  input  ld_kind_e            kind_i,
  input  logic [REG_AW-1:0]   rt_i,
  input  logic [REG_AW-1:0]   ra_i,
  input  logic [DATA_W-1:0]   ra_val_i,
  input  logic [DATA_W-1:0]   rb_val_i,
  input  logic [DISP_W-1:0]   disp_i,
  input  logic [NB_W-1:0]     nb_i,
  input  logic [TBC_W-1:0]    tbc_i,
  output logic [ADDR_W-1:0]   ea_o,
  output logic [CNT_W-1:0]    nbytes_o,
  output logic [REG_AW-1:0]   last_o
);
  localparam int BPR = DATA_W / 8;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    base     = (ra_i == '0) ? '0 : ADDR_W'(ra_val_i);
    disp_ext = {{(ADDR_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
    case (kind_i)
      K_MULTI: begin
        ea_o     = base + disp_ext;
        nbytes_o = CNT_W'((NREGS - int'(rt_i)) * BPR);
      end
      K_STR_IMM: begin
        ea_o     = base;
        nbytes_o = (nb_i == '0) ? CNT_W'(1 << NB_W) : CNT_W'(nb_i);
      end
      K_STR_IDX: begin
        ea_o     = base + ADDR_W'(rb_val_i);
        nbytes_o = CNT_W'(tbc_i);
      end
      default: begin
        ea_o     = base;
        nbytes_o = '0;
      end
    endcase
    last_o = wrap_reg(rt_i, regs_for(int'(nbytes_o), BPR) - 1);
  end
endmodule

// File: rtl/lms_pack.sv
module lms_pack #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic [7:0]        byte_i,
  output logic [DATA_W-1:0] word_o,
  output logic              full_o
);
  localparam int BPR = DATA_W / 8;
  localparam int PW  = (BPR > 1) ? $clog2(BPR) : 1;

  logic [DATA_W-1:0] acc_q;
  logic [PW-1:0]     pos_q;
  int                sh;

  // Current word with the incoming byte placed, highest lane first.
  always_comb begin
    word_o = acc_q;
    sh     = DATA_W - 8 - 8 * int'(pos_q);
    if (take_i) word_o[sh +: 8] = byte_i;
  end

  assign full_o = take_i && (pos_q == PW'(BPR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      pos_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      pos_q <= '0;
    end else if (take_i) begin
      if (full_o) begin
        acc_q <= '0;
        pos_q <= '0;
      end else begin
        acc_q <= word_o;
        pos_q <= pos_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/load_burst_seq.sv
module load_burst_seq import lms_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int NB_W   = 5,
  parameter int TBC_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        kind_i,
  input  logic [4:0]        rt_i,
  input  logic [4:0]        ra_i,
  input  logic [4:0]        rb_i,
  input  logic [DATA_W-1:0] ra_val_i,
  input  logic [DATA_W-1:0] rb_val_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [NB_W-1:0]   nb_i,
  input  logic [TBC_W-1:0]  tbc_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rdy_i,
  input  logic [7:0]        mem_byte_i,
  output logic              wr_en_o,
  output logic [4:0]        wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o
);
  localparam int BPR   = DATA_W / 8;
  localparam int CNT_W = $clog2(NREGS * BPR + 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q, setup_ea;
  logic [CNT_W-1:0]  rem_q, setup_n;
  logic [REG_AW-1:0] cur_q, last_q, ra_q, rb_q, setup_last;
  logic              idx_form_q;
  ld_kind_e          kind;

  // Named internal events
  logic launch, byte_take, final_byte, word_full, word_ready;
  logic guard_hit, commit, seq_busy;
  logic [DATA_W-1:0] word_now;

  assign kind = ld_kind_e'(kind_i);

  lms_setup #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W),
    .NB_W(NB_W), .TBC_W(TBC_W), .CNT_W(CNT_W)
  ) u_setup (
    .kind_i(kind), .rt_i(rt_i), .ra_i(ra_i),
    .ra_val_i(ra_val_i), .rb_val_i(rb_val_i), .disp_i(disp_i),
    .nb_i(nb_i), .tbc_i(tbc_i),
    .ea_o(setup_ea), .nbytes_o(setup_n), .last_o(setup_last)
  );

  lms_pack #(.DATA_W(DATA_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr_i(launch), .take_i(byte_take),
    .byte_i(mem_byte_i), .word_o(word_now), .full_o(word_full)
  );

  assign seq_busy   = (state_q != S_IDLE);
  assign launch     = start_i && !seq_busy;
  assign byte_take  = (state_q == S_RUN) && mem_rdy_i;
  assign final_byte = byte_take && (rem_q == CNT_W'(1));
  assign word_ready = word_full || final_byte;
  assign guard_hit  = ((cur_q == ra_q) || (idx_form_q && (cur_q == rb_q))) && (cur_q != last_q);
  assign commit     = word_ready && !guard_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      addr_q     <= '0;
      rem_q      <= '0;
      cur_q      <= '0;
      last_q     <= '0;
      ra_q       <= '0;
      rb_q       <= '0;
      idx_form_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (launch) begin
          addr_q     <= setup_ea;
          rem_q      <= setup_n;
          cur_q      <= rt_i;
          last_q     <= setup_last;
          ra_q       <= ra_i;
          rb_q       <= rb_i;
          idx_form_q <= (kind == K_STR_IDX);
          state_q    <= (setup_n == '0) ? S_DONE : S_RUN;
        end
        S_RUN: if (byte_take) begin
          addr_q <= addr_q + 1'b1;
          rem_q  <= rem_q - 1'b1;
          if (word_ready) cur_q <= cur_q + 1'b1;
          if (final_byte) state_q <= S_LAST;
        end
        S_LAST:  state_q <= S_DONE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= commit;
      if (commit) begin
        wr_idx_o  <= cur_q;
        wr_data_o <= word_now;
      end
    end
  end

  assign mem_req_o  = (state_q == S_RUN);
  assign mem_addr_o = addr_q;
  assign done_o     = (state_q == S_DONE);
endmodule

// File: rtl/load_burst_seq_chk.sv
module load_burst_seq_chk import lms_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              mem_req_o,
  input logic              mem_rdy_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              wr_en_o,
  input logic [4:0]        wr_idx_o,
  input logic              done_o,
  input logic              seq_busy,
  input logic              idx_form_q,
  input logic [REG_AW-1:0] ra_q,
  input logic [REG_AW-1:0] rb_q,
  input logic [REG_AW-1:0] last_q
);
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_rdy_i) |=> (!mem_req_o || (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1))));

  p_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> !(((wr_idx_o == ra_q) || (idx_form_q && (wr_idx_o == rb_q))) && (wr_idx_o != last_q)));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!mem_req_o && !wr_en_o));

  p_busy_from_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |-> $past(start_i));

  p_reset_idle_r12: assert property (@(posedge clk)
    !rst_n |=> (!mem_req_o && !wr_en_o && !done_o));
endmodule

bind load_burst_seq load_burst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .mem_req_o(mem_req_o), .mem_rdy_i(mem_rdy_i), .mem_addr_o(mem_addr_o),
  .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .done_o(done_o),
  .seq_busy(seq_busy), .idx_form_q(idx_form_q),
  .ra_q(ra_q), .rb_q(rb_q), .last_q(last_q)
);

// File: tb/load_burst_seq_test.sv
module load_burst_seq_test;
  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  rt, ra, rb;
    logic [31:0] ra_val, rb_val;
    logic [15:0] disp;
    logic [4:0]  nb;
    logic [6:0]  tbc;
    logic        stall;
    logic [7:0]  exp_n;
    logic [5:0]  exp_nwr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 5'd28, 5'd5,  5'd0,  32'h100,  32'h0,  16'hFFFC, 5'd0,  7'd0,   1'b0, 8'd16,  6'd4},  // R1 negative disp
    '{2'd0, 5'd29, 5'd30, 5'd0,  32'h200,  32'h0,  16'h0008, 5'd0,  7'd0,   1'b0, 8'd12,  6'd2},  // R7 RA shielded
    '{2'd0, 5'd30, 5'd31, 5'd0,  32'h300,  32'h0,  16'h0000, 5'd0,  7'd0,   1'b1, 8'd8,   6'd2},  // R7 RA final
    '{2'd0, 5'd31, 5'd0,  5'd0,  32'hDEAD, 32'h0,  16'h0040, 5'd0,  7'd0,   1'b1, 8'd4,   6'd1},  // R4 zero base
    '{2'd1, 5'd26, 5'd3,  5'd0,  32'h400,  32'h0,  16'h0,    5'd0,  7'd0,   1'b1, 8'd32,  6'd8},  // R2 R6 zero->32, wrap
    '{2'd1, 5'd31, 5'd2,  5'd0,  32'h500,  32'h0,  16'h0,    5'd7,  7'd0,   1'b0, 8'd7,   6'd2},  // R5 R6 partial tail
    '{2'd2, 5'd4,  5'd5,  5'd6,  32'h600,  32'h10, 16'h0,    5'd0,  7'd10,  1'b1, 8'd10,  6'd2},  // R3 R7 RB final
    '{2'd2, 5'd8,  5'd10, 5'd9,  32'h700,  32'h3,  16'h0,    5'd0,  7'd9,   1'b0, 8'd9,   6'd2},  // R3 R7 RB shielded
    '{2'd2, 5'd12, 5'd1,  5'd2,  32'h800,  32'h4,  16'h0,    5'd0,  7'd0,   1'b0, 8'd0,   6'd0},  // R8 empty
    '{2'd2, 5'd0,  5'd31, 5'd0,  32'h900,  32'h0,  16'h0,    5'd0,  7'd127, 1'b1, 8'd127, 6'd31}  // R6 R7 full wrap
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] kind = '0;
  logic [4:0] rt = '0, ra = '0, rb = '0;
  logic [31:0] ra_val = '0, rb_val = '0;
  logic [15:0] disp = '0;
  logic [4:0] nb = '0;
  logic [6:0] tbc = '0;
  logic mem_req, mem_rdy = 1'b0;
  logic [31:0] mem_addr;
  logic [7:0] mem_byte;
  logic wr_en, done;
  logic [4:0] wr_idx;
  logic [31:0] wr_data;

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign mem_byte = mem_fn(mem_addr);

  load_burst_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind),
    .rt_i(rt), .ra_i(ra), .rb_i(rb), .ra_val_i(ra_val), .rb_val_i(rb_val),
    .disp_i(disp), .nb_i(nb), .tbc_i(tbc),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdy_i(mem_rdy), .mem_byte_i(mem_byte),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data), .done_o(done)
  );

  int checks = 0, fails = 0;
  int cyc = 0, nwr = 0, nacc = 0, ndone = 0, addr_err = 0;
  int last_wr_cyc = 0, done_cyc = 0;
  logic stall_en = 1'b0;
  logic [31:0] first_addr = '0, prev_addr = '0;
  logic [4:0]  got_idx [64];
  logic [31:0] got_dat [64];

  // Monitor and memory ready generator, all at the falling edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_rdy = stall_en ? ((cyc % 3) != 0) : 1'b1;
    if (mem_req && mem_rdy) begin
      if (nacc == 0) first_addr = mem_addr;
      else if (mem_addr != prev_addr + 1) addr_err = addr_err + 1;
      prev_addr = mem_addr;
      nacc = nacc + 1;
    end
    if (wr_en) begin
      if (nwr < 64) begin
        got_idx[nwr] = wr_idx;
        got_dat[nwr] = wr_data;
      end
      nwr = nwr + 1;
      last_wr_cyc = cyc;
    end
    if (done) begin
      ndone = ndone + 1;
      done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string kind_tag(input logic [1:0] k);
    if (k == 2'd0) return "R1";
    if (k == 2'd1) return "R2";
    return "R3";
  endfunction

  task automatic drive(input vec_t v);
    kind = v.kind; rt = v.rt; ra = v.ra; rb = v.rb;
    ra_val = v.ra_val; rb_val = v.rb_val; disp = v.disp; nb = v.nb; tbc = v.tbc;
  endtask

  task automatic run_vec(input vec_t v, input bit poke, input vec_t other);
    logic [31:0] base, ea;
    int n, nreg, fin, k, e;
    string tg;
    nwr = 0; nacc = 0; ndone = 0; addr_err = 0;
    stall_en = v.stall;
    tg = kind_tag(v.kind);
    @(negedge clk); drive(v); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      @(negedge clk); drive(other); start = 1'b1;   // R11 start while busy
      @(negedge clk); start = 1'b0;
    end
    k = 0;
    while (ndone == 0 && k < 2000) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
    // Independent model of the transfer
    base = (v.ra == 0) ? 32'h0 : v.ra_val;                  // R4
    if (v.kind == 2'd0) begin ea = base + {{16{v.disp[15]}}, v.disp}; n = (32 - int'(v.rt)) * 4; end
    else if (v.kind == 2'd1) begin ea = base; n = (v.nb == 0) ? 32 : int'(v.nb); end
    else begin ea = base + v.rb_val; n = int'(v.tbc); end
    nreg = (n + 3) / 4;
    fin = (int'(v.rt) + nreg - 1) % 32;
    chk(n == int'(v.exp_n), tg, "table byte count", n, v.exp_n);
    chk(nacc == n, tg, "bytes fetched", nacc, n);
    chk(ndone == 1, "R10", "done pulses", ndone, 1);
    if (n == 0) begin
      chk(nwr == 0, "R8", "writes on empty", nwr, 0);
    end else begin
      chk(first_addr == ea, tg, "first address", first_addr, ea);
      chk(addr_err == 0, "R9", "address steps", addr_err, 0);
      chk(done_cyc == last_wr_cyc + 1, "R10", "done after last write", done_cyc, last_wr_cyc + 1);
      chk(nwr == int'(v.exp_nwr), "R7", "write count", nwr, v.exp_nwr);
      e = 0;
      for (int w = 0; w < nreg; w++) begin
        int idx;
        logic [31:0] d;
        idx = (int'(v.rt) + w) % 32;
        if ((idx == int'(v.ra) || (v.kind == 2'd2 && idx == int'(v.rb))) && idx != fin) continue;
        d = '0;
        for (int b = 0; b < 4; b++)
          if (4 * w + b < n) d[31 - 8*b -: 8] = mem_fn(ea + 32'(4 * w + b));
        if (e < nwr && e < 64) begin
          chk(got_idx[e] == 5'(idx), "R6", "register index", got_idx[e], idx);
          chk(got_dat[e] == d, "R5", "word data", got_dat[e], d);
        end
        e++;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!mem_req, "R12", "req in reset", mem_req, 0);
    chk(!wr_en, "R12", "write in reset", wr_en, 0);
    chk(!done, "R12", "done in reset", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!mem_req && !wr_en && !done, "R12", "idle after reset", {mem_req, wr_en, done}, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0, VECS[i]);

    // R11: a second start during a transfer must leave the first one intact
    run_vec(VECS[0], 1'b1, VECS[4]);
    // R8 again with the stalled memory
    run_vec(VECS[8], 1'b0, VECS[8]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails = fails + 1;
    checks = checks + 1;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule